// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets on-chip logic reach an external asynchronous, byte-wide static RAM through a simple request port. A client offers a request with a valid/ready handshake. The request carries a read/write flag, a 21-bit byte address and, for writes, one data byte. Reads return their byte with a one-cycle response strobe. On the memory side the block drives the address bus and three active-low strobes: select, output-enable and write-enable. It also handles a shared data bus through separate output, output-enable and input signals. The pad buffer sits outside the block.

The memory has no clock, so the block measures every phase in whole clock cycles. Each timing limit is a parameter in picoseconds, beside the clock period. Each phase length is the ceiling of its limit divided by the period, and never less than one cycle. A write is framed by select and write-enable low together, with output-enable held high. After every read the block waits out the memory's turn-off time before any cycle that could drive the bus. While it is busy, ready stays low and requests are ignored.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Throughout a read, {`mem_ce_n`,`mem_oe_n`,`mem_we_n`,`mem_dq_oe`} = 4'b0010. Output-enable low always implies select low, write-enable high and the data bus not driven.
- R3: Throughout a write pulse, {`mem_ce_n`,`mem_oe_n`,`mem_we_n`,`mem_dq_oe`} = 4'b0101, and `mem_dq_out` carries the request byte. Write-enable is never low while output-enable is low.
- R4: `rsp_valid` rises on the RD_CYC-th rising edge after the edge that accepted a read, and it is high for exactly one cycle. `rsp_rdata` holds the byte that `mem_dq_in` carried at that edge. For the default parameters RD_CYC = 1.
- R5: Write-enable stays low for exactly PULSE_CYC cycles. `mem_addr` and `mem_dq_out` stay stable through the pulse and through the edge on which write-enable rises. The bus stays driven for HOLD_CYC cycles after that edge.
- R6: The block and the memory never drive the bus together. After `mem_oe_n` rises, `mem_dq_oe` stays 0 for at least TURN_CYC+1 rising edges.
- R7: `mem_dq_oe` is low for at least one full cycle before `mem_oe_n` falls.
- R8: `req_ready` is 1 only when no access is in progress. After accepting a read it is 0 for RD_CYC+TURN_CYC cycles; after accepting a write, for PULSE_CYC+HOLD_CYC cycles. A valid request seen while ready is 0 leaves `mem_addr` unchanged and is taken only once ready returns.
- R9: Phase lengths are RD_CYC = max(ceil(tRC), ceil(tAA)), TURN_CYC = max(ceil(tOEoff), ceil(tCEoff)), PULSE_CYC = max over ceil of write pulse, address-to-end, select-to-end and data setup, and HOLD_CYC = WC_CYC−PULSE_CYC when that is positive, else 1. Every ceiling is taken in clock periods and floored at 1. With a 4 ns period parameter and the default limits this gives RD_CYC = 3, PULSE_CYC = 2, HOLD_CYC = 1 and TURN_CYC = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | DATA_W | Data from the pads |

## Verification
The hardest case to reach from the ports is the bus hand-over in both directions: a read followed at once by a write, and a write followed at once by a read. Here the block's drive window and the memory's turn-off window lie closest together. The bench chains requests by holding valid high across accepts. A timed memory model keeps driving unknown data for its full turn-off time after output-enable rises, and a 1 ns monitor counts every overlap of the two drivers. A second instance with a shorter nominal period stretches each phase to several cycles, so that the ceiling arithmetic is seen at the ports.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_TURN  = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_HOLD  = 3'd4
  } seq_state_t;

  // Cycles needed to cover t_ps at a clock of clk_ps, never below one.
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
`timescale 1ns/1ps
// Loadable down counter; expire is high during the last cycle of a phase.
module sramc_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sramc_sequencer.sv
`timescale 1ns/1ps
module sramc_sequencer
  import sramc_pkg::*;
#(
  parameter int CNT_W     = 2,
  parameter int RD_CYC    = 1,
  parameter int TURN_CYC  = 1,
  parameter int PULSE_CYC = 1,
  parameter int HOLD_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expire,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);

  seq_state_t state_q, state_d;
  logic ready_q, ce_q, oe_q, we_q, dqoe_q;
  logic ce_d, oe_d, we_d, dqoe_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    ce_d     = ce_q;
    oe_d     = oe_q;
    we_d     = we_q;
    dqoe_d   = dqoe_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && ready_q) begin
          accept = 1'b1;
          load   = 1'b1;
          ce_d   = 1'b0;
          if (req_write) begin
            state_d  = ST_WR_PULSE;
            load_val = CNT_W'(PULSE_CYC);
            we_d     = 1'b0;
            oe_d     = 1'b1;
            dqoe_d   = 1'b1;
          end else begin
            state_d  = ST_RD_ACC;
            load_val = CNT_W'(RD_CYC);
            oe_d     = 1'b0;
          end
        end
      end
      ST_RD_ACC: begin
        if (expire) begin
          capture  = 1'b1;
          state_d  = ST_RD_TURN;
          load     = 1'b1;
          load_val = CNT_W'(TURN_CYC);
          ce_d     = 1'b1;
          oe_d     = 1'b1;
        end
      end
      ST_RD_TURN: begin
        if (expire) state_d = ST_IDLE;
      end
      ST_WR_PULSE: begin
        if (expire) begin
          state_d  = ST_WR_HOLD;
          load     = 1'b1;
          load_val = CNT_W'(HOLD_CYC);
          ce_d     = 1'b1;
          we_d     = 1'b1;
        end
      end
      ST_WR_HOLD: begin
        if (expire) begin
          state_d = ST_IDLE;
          dqoe_d  = 1'b0;
        end
      end
      default: begin
        state_d = ST_IDLE;
        ce_d    = 1'b1;
        oe_d    = 1'b1;
        we_d    = 1'b1;
        dqoe_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      dqoe_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == ST_IDLE);
      ce_q    <= ce_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      dqoe_q  <= dqoe_d;
    end
  end

  assign ready = ready_q;
  assign ce_n  = ce_q;
  assign oe_n  = oe_q;
  assign we_n  = we_q;
  assign dq_oe = dqoe_q;

endmodule

// File: rtl/sramc_datapath.sv
`timescale 1ns/1ps
module sramc_datapath #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      dq_out    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        dq_out   <= req_wdata;
      end
      rsp_valid <= capture;
      if (capture) rsp_rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 20000,
  parameter int T_RC_PS    = 10000,
  parameter int T_AA_PS    = 10000,
  parameter int T_OEOFF_PS = 4000,
  parameter int T_CEOFF_PS = 4000,
  parameter int T_WC_PS    = 10000,
  parameter int T_PWE_PS   = 6500,
  parameter int T_AW_PS    = 8000,
  parameter int T_SCE_PS   = 8000,
  parameter int T_SD_PS    = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned RD_CYC = umax(ps_to_cycles(T_RC_PS, CLK_PS),
                                        ps_to_cycles(T_AA_PS, CLK_PS));
  localparam int unsigned TURN_CYC = umax(ps_to_cycles(T_OEOFF_PS, CLK_PS),
                                          ps_to_cycles(T_CEOFF_PS, CLK_PS));
  localparam int unsigned PULSE_CYC =
    umax(umax(ps_to_cycles(T_PWE_PS, CLK_PS), ps_to_cycles(T_AW_PS, CLK_PS)),
         umax(ps_to_cycles(T_SCE_PS, CLK_PS), ps_to_cycles(T_SD_PS, CLK_PS)));
  localparam int unsigned WC_CYC   = ps_to_cycles(T_WC_PS, CLK_PS);
  localparam int unsigned HOLD_CYC = (WC_CYC > PULSE_CYC) ? (WC_CYC - PULSE_CYC) : 1;
  localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, TURN_CYC), umax(PULSE_CYC, HOLD_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic             load, accept, capture, expire;
  logic [CNT_W-1:0] load_val;

  sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expire   (expire)
  );

  sramc_sequencer #(
    .CNT_W     (CNT_W),
    .RD_CYC    (int'(RD_CYC)),
    .TURN_CYC  (int'(TURN_CYC)),
    .PULSE_CYC (int'(PULSE_CYC)),
    .HOLD_CYC  (int'(HOLD_CYC))
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .expire    (expire),
    .load      (load),
    .load_val  (load_val),
    .accept    (accept),
    .capture   (capture),
    .ready     (req_ready),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe)
  );

  sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .dq_in     (mem_dq_in),
    .mem_addr  (mem_addr),
    .dq_out    (mem_dq_out),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sramc_checker.sv
`timescale 1ns/1ps
module sramc_checker #(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 8,
  parameter int TURN_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  localparam int GAP   = TURN_CYC + 1;
  localparam int GAP_W = $clog2(GAP + 1);

  // Rising edges seen with output-enable high, saturating at GAP.
  logic [GAP_W-1:0] since_oe_q;
  always_ff @(posedge clk) begin
    if (rst) since_oe_q <= GAP_W'(GAP);
    else if (!mem_oe_n) since_oe_q <= '0;
    else if (since_oe_q != GAP_W'(GAP)) since_oe_q <= since_oe_q + 1'b1;
  end

  assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_read_encoding_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

  assert_write_oe_high_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe));

  assert_rsp_single_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_write_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_write_end_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (since_oe_q >= GAP_W'(GAP)));

  assert_release_first_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n || mem_dq_oe) |-> !req_ready);

endmodule

bind sram_async_ctrl sramc_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .TURN_CYC (int'(TURN_CYC))
) u_sramc_checker (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  // Phase lengths worked out by hand from R9, default limits, 20 ns period.
  localparam int RD_E = 1, TURN_E = 1, PULSE_E = 1, HOLD_E = 1;
  // Same limits with a 4 ns period parameter.
  localparam int S_RD_E = 3, S_TURN_E = 1, S_PULSE_E = 2, S_HOLD_E = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [20:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  // Second instance: nominal 4 ns period stretches every phase (R9).
  logic        s_valid = 1'b0, s_write = 1'b0;
  logic        s_ready, s_rsp_valid, s_ce_n, s_oe_n, s_we_n, s_dq_oe;
  logic [7:0]  s_rdata, s_dq_out;
  logic [20:0] s_addr;
  sram_async_ctrl #(.CLK_PS(4000)) i_sram_async_ctrl_slow (
    .clk(clk), .rst(rst), .req_valid(s_valid), .req_ready(s_ready),
    .req_write(s_write), .req_addr(21'h0ABCDE), .req_wdata(8'hC3),
    .rsp_valid(s_rsp_valid), .rsp_rdata(s_rdata), .mem_addr(s_addr),
    .mem_ce_n(s_ce_n), .mem_oe_n(s_oe_n), .mem_we_n(s_we_n),
    .mem_dq_out(s_dq_out), .mem_dq_oe(s_dq_oe), .mem_dq_in(8'h5A));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // ---------------- timed memory model ----------------
  logic [7:0] mem_q [int unsigned];
  logic [7:0] shadow [int unsigned];
  logic       mem_drv = 1'b0;
  logic [7:0] mem_val = 8'h00;
  int         clash_cnt = 0, short_wr_cnt = 0;

  always_comb mem_dq_in = mem_drv ? mem_val : (mem_dq_oe ? mem_dq_out : 8'h00);

  initial begin
    real t_rd_on, t_rd_off, t_wr_on;
    logic rd_d, wr_d;
    logic [20:0] addr_d;
    logic [7:0] dq_d;
    t_rd_on = 0.0; t_rd_off = 0.0; t_wr_on = 0.0;
    rd_d = 1'b0; wr_d = 1'b0; addr_d = '0; dq_d = '0;
    #0.5;
    forever begin
      logic rd, wr;
      #1;
      rd = !mem_ce_n && !mem_oe_n && mem_we_n;
      wr = !mem_ce_n && !mem_we_n;
      if (rd && (!rd_d || mem_addr != addr_d)) t_rd_on = $realtime;
      if (!rd && rd_d) t_rd_off = $realtime;
      if (rd) begin
        mem_drv = 1'b1;
        if ($realtime - t_rd_on >= 10.0)
          mem_val = mem_q.exists(int'(mem_addr)) ? mem_q[int'(mem_addr)] : 8'h00;
        else
          mem_val = 8'hxx;
      end else if (mem_drv) begin
        mem_val = 8'hxx;
        if ($realtime - t_rd_off >= 4.0) mem_drv = 1'b0;
      end
      if (wr && !wr_d) t_wr_on = $realtime;
      if (!wr && wr_d) begin
        mem_q[int'(addr_d)] = dq_d;
        if ($realtime - t_wr_on < 8.0) short_wr_cnt++;
      end
      if (mem_drv && mem_dq_oe) clash_cnt++;
      rd_d = rd; wr_d = wr; addr_d = mem_addr; dq_d = mem_dq_out;
    end
  end

  // ---------------- bus hand-over monitor (R6, R7) ----------------
  int  ncnt = 0, t_oe_rise = -100, t_dq_fall = -100;
  logic p_oe = 1'b1, p_dq = 1'b0;
  always @(negedge clk) begin
    ncnt++;
    if (!rst) begin
      if (mem_oe_n && !p_oe) t_oe_rise = ncnt;
      if (!mem_dq_oe && p_dq) t_dq_fall = ncnt;
      if (mem_dq_oe && !p_dq && t_oe_rise > 0)
        chk((ncnt - t_oe_rise) >= TURN_E + 1, "R6 oe_n rise to bus drive gap",
            ncnt - t_oe_rise, TURN_E + 1);
      if (!mem_oe_n && p_oe && t_dq_fall > 0)
        chk((ncnt - t_dq_fall) >= 1, "R7 bus release before read",
            ncnt - t_dq_fall, 1);
    end
    p_oe = mem_oe_n; p_dq = mem_dq_oe;
  end

  // ---------------- scenario tasks ----------------
  task automatic do_write(input logic [20:0] a, input logic [7:0] d);
    int k, we_low;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    shadow[int'(a)] = d;
    k = 0; we_low = 0;
    while (k < 50) begin
      @(negedge clk); k++;
      if (req_ready) break;
      if (!mem_we_n) we_low++;
      if (k == 1) begin
        chk_eq("R3 write strobes {ce,oe,we,dqoe}",
               {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0101);
        chk_eq("R3 write data on bus", mem_dq_out, d);
      end
      chk_eq("R5 address held during write", mem_addr, a);
    end
    chk_eq("R5 write pulse cycles", we_low, PULSE_E);
    chk_eq("R8 busy cycles after write", k - 1, PULSE_E + HOLD_E);
  endtask

  task automatic do_read(input logic [20:0] a);
    int k, lat, pulses;
    logic [7:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    k = 0; lat = -1; pulses = 0;
    while (k < 50) begin
      @(negedge clk); k++;
      if (rsp_valid) begin
        pulses++;
        if (lat < 0) begin
          lat = k - 1;
          chk_eq("R4 read data", rsp_rdata, exp);
        end
      end
      if (req_ready) break;
      if (k == 1)
        chk_eq("R2 read strobes {ce,oe,we,dqoe}",
               {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
    end
    chk_eq("R4 read latency", lat, RD_E);
    chk_eq("R4 single response pulse", pulses, 1);
    chk_eq("R8 busy cycles after read", k - 1, RD_E + TURN_E);
  endtask

  task automatic test_reset;
    chk_eq("R1 strobes high in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    chk_eq("R1 bus drive off", mem_dq_oe, 1'b0);
    chk_eq("R1 ready high", req_ready, 1'b1);
    chk_eq("R1 no response", rsp_valid, 1'b0);
  endtask

  task automatic test_patterns;
    do_write(21'h000000, 8'hA5);
    do_write(21'h1FFFFF, 8'h3C);
    do_write(21'h0AAAAA, 8'hFF);
    do_write(21'h155555, 8'h00);
    do_read(21'h000000);
    do_read(21'h1FFFFF);
    do_read(21'h0AAAAA);
    do_read(21'h155555);
    do_write(21'h000000, 8'h5A);
    do_read(21'h000000);
  endtask

  // Write then read with valid held high across the accept (R6, R7, R8).
  task automatic test_chained;
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h012345; req_wdata = 8'h96;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    shadow[int'(21'h012345)] = 8'h96;
    req_write = 1'b0; req_addr = 21'h012345;
    k = 0;
    while (k < 20) begin
      @(negedge clk); k++;
      if (req_ready) break;
      if (k == 1) req_addr = 21'h012345;
    end
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h054321; req_wdata = 8'h69;
    k = 0;
    while (k < 50) begin
      @(negedge clk); k++;
      if (rsp_valid) chk_eq("R4 chained read data", rsp_rdata, 8'h96);
      if (req_ready) break;
      chk_eq("R8 request ignored while busy", mem_addr, 21'h012345);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    shadow[int'(21'h054321)] = 8'h69;
    repeat (4) @(negedge clk);
    do_read(21'h054321);
  endtask

  task automatic test_slow_timing;
    int k, lat, low;
    @(negedge clk);
    s_valid = 1'b1; s_write = 1'b0;
    while (!s_ready) @(negedge clk);
    @(posedge clk); #1;
    s_valid = 1'b0;
    k = 0; lat = -1;
    while (k < 50) begin
      @(negedge clk); k++;
      if (s_rsp_valid && lat < 0) begin
        lat = k - 1;
        chk_eq("R4 slow read data", s_rdata, 8'h5A);
      end
      if (s_ready) break;
    end
    chk_eq("R9 slow read latency", lat, S_RD_E);
    chk_eq("R9 slow read busy cycles", k - 1, S_RD_E + S_TURN_E);
    @(negedge clk);
    s_valid = 1'b1; s_write = 1'b1;
    @(posedge clk); #1;
    s_valid = 1'b0;
    k = 0; low = 0;
    while (k < 50) begin
      @(negedge clk); k++;
      if (s_ready) break;
      if (!s_we_n) begin
        low++;
        chk_eq("R9 slow write oe high", s_oe_n, 1'b1);
      end
    end
    chk_eq("R9 slow write pulse", low, S_PULSE_E);
    chk_eq("R9 slow write busy cycles", k - 1, S_PULSE_E + S_HOLD_E);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_patterns();
    test_chained();
    test_slow_timing();
    repeat (4) @(negedge clk);
    chk_eq("R6 no bus clash", clash_cnt, 0);
    chk_eq("R5 memory saw full write window", short_wr_cnt, 0);
    finish_run();
  end

endmodule